// File: doc/BRIEF.md
# Multi-Cycle Complex Integer Execution Unit

This block runs the integer operations that are too slow or too rare for the single-cycle ALU: logical and arithmetic shifts, rotates, a 32-bit multiply and an unsigned divide. It takes one operation at a time from the complex-integer issue slot through a valid/ready handshake. Each operation finishes after a fixed latency that depends only on its class: 4 cycles for shifts and rotates, 14 for multiply and 60 for divide. The result leaves through a single result port, marked by a one-cycle valid pulse.

Internally, a control module counts cycles and sends a small set of strobes to a datapath. The datapath does shifts in one pass through two barrel rotators. It multiplies several multiplier bits per step and divides one quotient bit per step. Because the latency is fixed, the issue logic upstream can plan the writeback slot at issue time. The unit does not overlap operations: a new one is taken only once the previous one has delivered its result.

Top module: `cx_int_unit`

## Requirements
- R1: After reset `inReady` is 1. An operation is accepted on a rising edge where `inValid` and `inReady` are both 1. `inReady` is 0 from the cycle after acceptance until the cycle in which the result is valid, and it is 1 again in that cycle. `outValid` is never 1 without an accepted operation in flight.
- R2: Operation codes 0 to 4 (shifts and rotates) raise `outValid` exactly 4 cycles after the accepting edge.
- R3: Operation code 5 (multiply) raises `outValid` exactly 14 cycles after the accepting edge.
- R4: Operation code 6 (divide) raises `outValid` exactly 60 cycles after the accepting edge.
- R5: Code 0 shifts `opA` left. Code 1 shifts it right, filling with zeros. Code 2 shifts it right, filling with copies of bit 31. The shift amount is `opB[4:0]`, and bits 31..5 of `opB` have no effect.
- R6: Code 3 rotates `opA` left and code 4 rotates it right, each by `opB[4:0]`.
- R7: Code 5 returns the low 32 bits of the unsigned product `opA*opB` on `outResult`.
- R8: Code 6 with a nonzero `opB` returns the unsigned quotient `opA/opB` on `outResult` and the remainder `opA%opB` on `outRemainder`.
- R9: Code 6 with `opB`=0 returns all ones on `outResult`, returns `opA` on `outRemainder`, and sets `outDivZero` to 1. Every other completion sets `outDivZero` to 0.
- R10: Code 7 is a no-op. It completes 4 cycles after acceptance with `outResult`=0. Every code other than 6 returns `outRemainder`=0.
- R11: `outValid` is a single-cycle pulse. `outResult`, `outRemainder` and `outDivZero` change only in a cycle where `outValid` is 1 and otherwise hold. `inValid` while `inReady` is 0 has no effect.
- R12: During reset, `outValid`=0, `inReady`=1, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can accept an operation |
| inOp | input | 3 | Operation code (0 shl, 1 shr, 2 sar, 3 rol, 4 ror, 5 mul, 6 div, 7 no-op) |
| opA | input | 32 | First operand (value shifted, multiplicand, dividend) |
| opB | input | 32 | Second operand (amount, multiplier, divisor) |
| outValid | output | 1 | One-cycle completion pulse |
| outResult | output | 32 | Result or quotient |
| outRemainder | output | 32 | Remainder for divide, otherwise 0 |
| outDivZero | output | 1 | Divide by zero flag of the latest completion |

## Verification
On every cycle, the bound checker tracks the in-flight operation with its own cycle counter. From that it checks that `inReady` stays low while the operation is in flight, that each completion lands on its class latency, and that the valid pulse lasts one cycle. It also checks that the result ports hold between completions, that a divide satisfies quotient times divisor plus remainder equals the dividend, and what a divide by zero returns. The bench's scenarios are needed for the exact bit patterns of each shift and rotate, for the upper bits of the shift operand having no effect, and for the multiply low word on chosen corner values. They also cover back-to-back issue in the completion cycle and operations offered while the unit is busy being ignored.

// File: rtl/cx_int_pkg.sv
package cx_int_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_MUL = 3'd5,
    OP_DIV = 3'd6,
    OP_NOP = 3'd7
  } cxOp_t;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'd0,
    CLS_MUL   = 2'd1,
    CLS_DIV   = 2'd2,
    CLS_NONE  = 2'd3
  } cxClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands, do single-pass work
    logic step;    // one iteration of multiply or divide
    logic finish;  // move working state to the result registers
  } cxStrobe_t;

  function automatic cxClass_t classOf(cxOp_t op);
    case (op)
      OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR: classOf = CLS_SHIFT;
      OP_MUL:  classOf = CLS_MUL;
      OP_DIV:  classOf = CLS_DIV;
      default: classOf = CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cx_int_rot.sv
// Logarithmic right rotator, one stage per amount bit.
module cx_int_rot #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  dataIn,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dataOut
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = dataIn;

  for (genvar i = 0; i < SW; i++) begin : gStage
    localparam int SH = 1 << i;
    assign stage[i+1] = amt[i] ? {stage[i][SH-1:0], stage[i][W-1:SH]} : stage[i];
  end

  assign dataOut = stage[SW];
endmodule

// File: rtl/cx_int_ctrl.sv
module cx_int_ctrl
  import cx_int_pkg::*;
#(
  parameter int SHIFT_LAT = 4,
  parameter int MUL_LAT   = 14,
  parameter int DIV_LAT   = 60,
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [2:0] inOp,
  output logic      inReady,
  output logic      outValid,
  output cxStrobe_t strobe
);
  localparam int MAX_A   = (SHIFT_LAT > MUL_LAT) ? SHIFT_LAT : MUL_LAT;
  localparam int MAX_LAT = (MAX_A > DIV_LAT) ? MAX_A : DIV_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] latR;
  logic [CW-1:0] stepsR;
  logic [CW-1:0] latSel;
  logic [CW-1:0] stepsSel;
  logic          outValidR;
  logic          accept;
  logic          fire;

  always_comb begin
    case (classOf(cxOp_t'(inOp)))
      CLS_MUL: begin
        latSel   = CW'(MUL_LAT);
        stepsSel = CW'(MUL_STEPS);
      end
      CLS_DIV: begin
        latSel   = CW'(DIV_LAT);
        stepsSel = CW'(DIV_STEPS);
      end
      default: begin
        latSel   = CW'(SHIFT_LAT);
        stepsSel = '0;
      end
    endcase
  end

  assign accept = inValid && !busy;
  assign fire   = busy && (cnt == latR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      latR      <= '0;
      stepsR    <= '0;
      outValidR <= 1'b0;
    end else begin
      outValidR <= fire;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= CW'(1);
        latR   <= latSel;
        stepsR <= stepsSel;
      end else if (fire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign inReady       = !busy;
  assign outValid      = outValidR;
  assign strobe.load   = accept;
  assign strobe.step   = busy && (cnt <= stepsR);
  assign strobe.finish = fire;
endmodule

// File: rtl/cx_int_dpath.sv
module cx_int_dpath
  import cx_int_pkg::*;
#(
  parameter int W        = 32,
  parameter int MUL_BITS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  cxStrobe_t    strobe,
  input  logic [2:0]   inOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] outResult,
  output logic [W-1:0] outRemainder,
  output logic         outDivZero
);
  localparam int SW = $clog2(W);

  cxOp_t        opR;
  logic [W-1:0] dividendR;
  logic [W-1:0] divisorR;
  logic [W-1:0] acc;
  logic [W-1:0] mcand;
  logic [W-1:0] mplier;
  logic [W-1:0] quo;
  logic [W-1:0] rem;
  logic [W-1:0] resR;
  logic [W-1:0] remR;
  logic         dzR;

  // ---------------- single-pass shifter ----------------
  logic [SW-1:0] amt;
  logic [SW-1:0] amtNeg;
  logic [W-1:0]  rotRight;
  logic [W-1:0]  rotLeft;
  logic [W-1:0]  keepRight;
  logic [W-1:0]  keepLeft;
  logic [W-1:0]  shiftRes;

  assign amt    = opB[SW-1:0];
  assign amtNeg = ~amt + {{(SW-1){1'b0}}, 1'b1};

  cx_int_rot #(.W(W)) uRotR (.dataIn(opA), .amt(amt),    .dataOut(rotRight));
  cx_int_rot #(.W(W)) uRotL (.dataIn(opA), .amt(amtNeg), .dataOut(rotLeft));

  assign keepRight = {W{1'b1}} >> amt;
  assign keepLeft  = {W{1'b1}} << amt;

  always_comb begin
    case (cxOp_t'(inOp))
      OP_SHL:  shiftRes = rotLeft & keepLeft;
      OP_SHR:  shiftRes = rotRight & keepRight;
      OP_SAR:  shiftRes = (rotRight & keepRight) | (opA[W-1] ? ~keepRight : '0);
      OP_ROL:  shiftRes = rotLeft;
      OP_ROR:  shiftRes = rotRight;
      default: shiftRes = '0;
    endcase
  end

  // ---------------- multiply step ----------------
  logic [MUL_BITS-1:0] digit;
  logic [W-1:0]        partial;

  assign digit   = mplier[MUL_BITS-1:0];
  assign partial = mcand * {{(W-MUL_BITS){1'b0}}, digit};

  // ---------------- restoring divide step ----------------
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  assign trial = {rem, quo[W-1]};
  assign diff  = trial - {1'b0, divisorR};
  assign fits  = trial >= {1'b0, divisorR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR       <= OP_NOP;
      dividendR <= '0;
      divisorR  <= '0;
      acc       <= '0;
      mcand     <= '0;
      mplier    <= '0;
      quo       <= '0;
      rem       <= '0;
    end else if (strobe.load) begin
      opR       <= cxOp_t'(inOp);
      dividendR <= opA;
      divisorR  <= opB;
      acc       <= (classOf(cxOp_t'(inOp)) == CLS_SHIFT) ? shiftRes : '0;
      mcand     <= opA;
      mplier    <= opB;
      quo       <= opA;
      rem       <= '0;
    end else if (strobe.step) begin
      if (classOf(opR) == CLS_MUL) begin
        acc    <= acc + partial;
        mcand  <= mcand << MUL_BITS;
        mplier <= mplier >> MUL_BITS;
      end else if (classOf(opR) == CLS_DIV) begin
        rem <= fits ? diff[W-1:0] : trial[W-1:0];
        quo <= {quo[W-2:0], fits};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resR <= '0;
      remR <= '0;
      dzR  <= 1'b0;
    end else if (strobe.finish) begin
      case (classOf(opR))
        CLS_DIV: begin
          if (divisorR == '0) begin
            resR <= '1;
            remR <= dividendR;
            dzR  <= 1'b1;
          end else begin
            resR <= quo;
            remR <= rem;
            dzR  <= 1'b0;
          end
        end
        CLS_NONE: begin
          resR <= '0;
          remR <= '0;
          dzR  <= 1'b0;
        end
        default: begin
          resR <= acc;
          remR <= '0;
          dzR  <= 1'b0;
        end
      endcase
    end
  end

  assign outResult    = resR;
  assign outRemainder = remR;
  assign outDivZero   = dzR;
endmodule

// File: rtl/cx_int_unit.sv
module cx_int_unit
  import cx_int_pkg::*;
#(
  parameter int W         = 32,
  parameter int MUL_BITS  = 4,
  parameter int SHIFT_LAT = 4,
  parameter int MUL_LAT   = 14,
  parameter int DIV_LAT   = 60
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [2:0]   inOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         outValid,
  output logic [W-1:0] outResult,
  output logic [W-1:0] outRemainder,
  output logic         outDivZero
);
  localparam int MUL_STEPS = W / MUL_BITS;
  localparam int DIV_STEPS = W;

  cxStrobe_t strobe;

  cx_int_ctrl #(
    .SHIFT_LAT(SHIFT_LAT),
    .MUL_LAT  (MUL_LAT),
    .DIV_LAT  (DIV_LAT),
    .MUL_STEPS(MUL_STEPS),
    .DIV_STEPS(DIV_STEPS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inOp    (inOp),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  cx_int_dpath #(
    .W       (W),
    .MUL_BITS(MUL_BITS)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inOp        (inOp),
    .opA         (opA),
    .opB         (opB),
    .outResult   (outResult),
    .outRemainder(outRemainder),
    .outDivZero  (outDivZero)
  );
endmodule

// File: rtl/cx_int_chk.sv
module cx_int_chk
  import cx_int_pkg::*;
#(
  parameter int W         = 32,
  parameter int SHIFT_LAT = 4,
  parameter int MUL_LAT   = 14,
  parameter int DIV_LAT   = 60
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic [2:0]   inOp,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         outValid,
  input logic [W-1:0] outResult,
  input logic [W-1:0] outRemainder,
  input logic         outDivZero
);
  localparam int DW = 2 * W;
  localparam int CW = 8;

  logic          pending;
  logic [CW-1:0] cnt;
  cxClass_t      pendCls;
  logic [W-1:0]  pendA;
  logic [W-1:0]  pendB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      cnt     <= '0;
      pendCls <= CLS_NONE;
      pendA   <= '0;
      pendB   <= '0;
    end else if (inValid && inReady) begin
      pending <= 1'b1;
      cnt     <= '0;
      pendCls <= classOf(cxOp_t'(inOp));
      pendA   <= opA;
      pendB   <= opB;
    end else if (outValid) begin
      pending <= 1'b0;
    end else if (pending) begin
      cnt <= cnt + CW'(1);
    end
  end

  assert_ready_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !outValid) |-> !inReady);

  assert_no_orphan_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> pending);

  assert_shift_lat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_SHIFT) |-> (cnt == CW'(SHIFT_LAT)));

  assert_mul_lat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_MUL) |-> (cnt == CW'(MUL_LAT)));

  assert_div_lat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_DIV) |-> (cnt == CW'(DIV_LAT)));

  assert_mul_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_MUL) |-> (outResult == W'(DW'(pendA) * DW'(pendB))));

  assert_div_identity_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_DIV && pendB != '0) |->
      ((DW'(outResult) * DW'(pendB) + DW'(outRemainder) == DW'(pendA)) &&
       (outRemainder < pendB) && !outDivZero));

  assert_div_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_DIV && pendB == '0) |->
      (outDivZero && outResult == '1 && outRemainder == pendA));

  assert_nop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pendCls == CLS_NONE) |->
      (cnt == CW'(SHIFT_LAT) && outResult == '0 && outRemainder == '0));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(outResult) || !$stable(outRemainder) || !$stable(outDivZero)) |-> outValid);
endmodule

bind cx_int_unit cx_int_chk #(
  .W        (W),
  .SHIFT_LAT(SHIFT_LAT),
  .MUL_LAT  (MUL_LAT),
  .DIV_LAT  (DIV_LAT)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inReady     (inReady),
  .inOp        (inOp),
  .opA         (opA),
  .opB         (opB),
  .outValid    (outValid),
  .outResult   (outResult),
  .outRemainder(outRemainder),
  .outDivZero  (outDivZero)
);

// File: tb/tb_cx_int_unit.sv
`timescale 1ns/1ps
module tb_cx_int_unit;
  localparam int W = 32;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [2:0]   inOp = 3'd0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         outValid;
  logic [W-1:0] outResult;
  logic [W-1:0] outRemainder;
  logic         outDivZero;

  always #10 clk = ~clk;  // 50 MHz

  cx_int_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .opA(opA), .opB(opB), .outValid(outValid),
    .outResult(outResult), .outRemainder(outRemainder), .outDivZero(outDivZero)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit running = 0;

  // ---------------- reference model ----------------
  bit           mBusy = 0;
  bit           wasBusy = 0;
  int           mLeft = 0;
  bit           mValid = 0;
  logic [W-1:0] mRes = '0;
  logic [W-1:0] mRem = '0;
  bit           mDz = 0;
  logic [2:0]   pOp = 3'd0;
  logic [W-1:0] pA = '0;
  logic [W-1:0] pB = '0;
  string        valTag = "R12";
  string        latTag = "R1";

  function automatic int latOf(logic [2:0] op);
    if (op == 3'd5) return 14;
    if (op == 3'd6) return 60;
    return 4;
  endfunction

  function automatic string latTagOf(logic [2:0] op);
    if (op <= 3'd4) return "R2";
    if (op == 3'd5) return "R3";
    if (op == 3'd6) return "R4";
    return "R10";
  endfunction

  function automatic string valTagOf(logic [2:0] op, logic [W-1:0] b);
    if (op <= 3'd2) return "R5";
    if (op <= 3'd4) return "R6";
    if (op == 3'd5) return "R7";
    if (op == 3'd6) return (b == '0) ? "R9" : "R8";
    return "R10";
  endfunction

  task automatic calc(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      output logic [W-1:0] r, output logic [W-1:0] rm, output bit dz);
    int sh;
    sh = int'(b[4:0]);
    rm = '0;
    dz = 0;
    case (op)
      3'd0: r = a << sh;
      3'd1: r = a >> sh;
      3'd2: r = W'($signed(a) >>> sh);
      3'd3: r = (sh == 0) ? a : ((a << sh) | (a >> (W - sh)));
      3'd4: r = (sh == 0) ? a : ((a >> sh) | (a << (W - sh)));
      3'd5: r = a * b;
      3'd6: begin
        if (b == '0) begin
          r = '1; rm = a; dz = 1;
        end else begin
          r = a / b; rm = a % b;
        end
      end
      default: r = '0;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mLeft = 0; mValid = 0; mRes = '0; mRem = '0; mDz = 0;
    end else begin
      wasBusy = mBusy;
      mValid = 0;
      if (mBusy) begin
        if (mLeft == 1) begin
          mBusy = 0;
          mValid = 1;
          calc(pOp, pA, pB, mRes, mRem, mDz);
          valTag = valTagOf(pOp, pB);
        end else begin
          mLeft = mLeft - 1;
        end
      end
      if (!wasBusy && inValid) begin
        mBusy = 1;
        mLeft = latOf(inOp);
        pOp = inOp; pA = opA; pB = opB;
        latTag = latTagOf(inOp);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      finishRun();
    end
    if (running && rstN) begin
      check(inReady == !mBusy, "R1", "inReady", W'(inReady), W'(!mBusy));
      check(outValid == mValid, mValid ? latTag : (mBusy ? latTag : "R11"),
            "outValid", W'(outValid), W'(mValid));
      check(outResult == mRes, mValid ? valTag : "R11", "outResult", outResult, mRes);
      check(outRemainder == mRem, mValid ? valTag : "R10", "outRemainder", outRemainder, mRem);
      check(outDivZero == mDz, "R9", "outDivZero", W'(outDivZero), W'(mDz));
    end
  end

  // issue one operation; starts and ends on a falling edge
  task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inOp = op; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0; opA = ~a; opB = ~b;
  endtask

  // issue, then keep offering a different operation while busy (R11)
  task automatic issueNoisy(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    issue(op, a, b);
    while (!inReady) begin
      inValid = 1'b1; inOp = 3'd5; opA = $urandom(); opB = $urandom();
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic drain();
    while (!inReady || mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(outValid == 1'b0, "R12", "outValid in reset", W'(outValid), '0);
    check(inReady == 1'b1, "R12", "inReady in reset", W'(inReady), W'(1));
    check(outResult == '0, "R12", "outResult in reset", outResult, '0);
    check(outRemainder == '0, "R12", "outRemainder in reset", outRemainder, '0);
    rstN = 1'b1;
    running = 1;
    @(negedge clk);

    // R5 shifts, including amount 0, 31 and ignored upper bits of opB
    issue(3'd0, 32'h8000_0001, 32'd1);
    issue(3'd0, 32'hDEAD_BEEF, 32'hFFFF_FFE4);
    issue(3'd1, 32'hF000_000F, 32'd31);
    issue(3'd1, 32'h1234_5678, 32'd0);
    issue(3'd2, 32'h8000_0000, 32'd31);
    issue(3'd2, 32'h7000_0000, 32'h0000_0104);
    // R6 rotates
    issue(3'd3, 32'h8000_0001, 32'd1);
    issue(3'd3, 32'h1234_5678, 32'd16);
    issue(3'd4, 32'h0000_0001, 32'd1);
    issue(3'd4, 32'hCAFE_F00D, 32'hFFFF_FFE0);
    // R7 multiply corners
    issue(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(3'd5, 32'h0001_0000, 32'h0001_0000);
    issue(3'd5, 32'h0000_0000, 32'h1234_5678);
    issue(3'd5, 32'h0000_BEEF, 32'h0000_1001);
    // R8 divide, R9 divide by zero
    issue(3'd6, 32'd100, 32'd7);
    issue(3'd6, 32'd5, 32'd9);
    issue(3'd6, 32'hFFFF_FFFF, 32'd1);
    issue(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(3'd6, 32'hABCD_1234, 32'd0);
    issue(3'd6, 32'd0, 32'd0);
    issue(3'd5, 32'd3, 32'd3);   // R9 flag clears on next completion
    // R10 no-op code
    issue(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R11 offers while busy are ignored
    issueNoisy(3'd6, 32'd1000, 32'd33);
    issueNoisy(3'd0, 32'h0000_00FF, 32'd4);
    drain();

    // mixed traffic, back-to-back where the unit allows
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      logic [W-1:0] b;
      op = 3'($urandom_range(0, 7));
      b = ($urandom_range(0, 5) == 0) ? '0 : $urandom();
      issue(op, $urandom(), b);
    end
    drain();
    finishRun();
  end
endmodule